// File: doc/BRIEF.md
# Register-Driven Three-Tap FIR Filter Peripheral

This peripheral sits on a simple request/response register bus and filters a stream of fixed-point samples. Software pushes samples one at a time by writing to a single data address. The samples wait in an input queue. A fixed-weight three-tap filter takes them from that queue and places the filtered values in an output queue. Software pops results from a second data address. Two count registers tell software how many entries wait in each queue, so it can avoid overfilling the input side or reading an empty output side.

The weights are fixed in hardware. The oldest sample of each window has weight 3, the middle one weight 2 and the newest one weight 1. Samples carry 3 fractional bits, so 1.0 is written as 8. The filter needs no scaling because every weight is an integer. The block decodes a 4 KiB window whose low 12 address bits select the register. In the system map the window is placed at 0x2000, so the four registers appear at 0x2000, 0x2008, 0x2100 and 0x2108.

Top module: `mmio_fir_accel`

## Requirements
- R1: The register offsets within the window are: sample push (write) 0x000, input-queue count (read) 0x008, result pop (read) 0x100, output-queue count (read) 0x108. Each count is returned zero-extended in the low bits of the read data.
- R2: For accepted samples x[0], x[1], … since reset, result k equals 3·x[k] + 2·x[k+1] + x[k+2]. It is computed exactly in 20-bit two's complement and returned as those 20 bits, zero-extended into the 64-bit read data.
- R3: The first two samples after reset produce no result. From the third sample on, each sample produces exactly one result, in arrival order.
- R4: Each queue holds 16 entries. A sample write that arrives while the input queue holds 16 entries is dropped and never appears in any later result.
- R5: A read of the result address while the output queue is empty returns zero and removes nothing.
- R6: The filter moves at most one sample per clock, and only when the input queue is not empty and the output queue is not full. While the output queue is full it stalls without losing or reordering data. Once one result is popped from a full output queue, exactly one sample moves on the following clock.
- R7: Read data appears on the first rising edge after the read request and stays zero in any cycle that follows a non-read cycle.
- R8: A read of any offset other than the two count addresses and the result address returns zero. A write to any offset other than the sample address changes no state.
- R9: A synchronous active-low reset empties both queues and clears the delay line and the warm-up state.
- R10: A sample is the low 16 bits of the write data, taken as a signed value. Bits 63:16 of the write data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 12 | Register offset within the window |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, registered, valid one cycle after a read |

## Verification
A corrupted queue pointer or count shows up at the ports as soon as software reads a count register or pops a result: the count differs from the number of accepted samples, or a result arrives out of order. A wrong delay-line or warm-up state changes the very first result after reset, or the second, so warm-up is checked directly after reset. Stall faults stay hidden until the output queue fills. For that reason the bench drives the block into the double-full state and then drains 32 results. A lost, duplicated or dropped-by-mistake sample shifts every later expected value, so a single fault of this kind fails many checks in a row.

// File: rtl/fir_accel_pkg.sv
// fir_accel_pkg: register offsets and the filter weighting shared by the
// peripheral. Assumes a 12-bit window offset.
package fir_accel_pkg;

    localparam logic [11:0] OFS_SAMPLE_PUSH = 12'h000;
    localparam logic [11:0] OFS_IN_LEVEL    = 12'h008;
    localparam logic [11:0] OFS_RESULT_POP  = 12'h100;
    localparam logic [11:0] OFS_OUT_LEVEL   = 12'h108;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PUSH,
        SEL_IN_LEVEL,
        SEL_POP,
        SEL_OUT_LEVEL
    } reg_sel_e;

    // Integer tap weights, index 0 = newest sample.
    function automatic int unsigned tap_weight(input int unsigned idx);
        return idx + 1;
    endfunction

endpackage

// File: rtl/fir_sync_queue.sv
// fir_sync_queue: single-clock circular queue with occupancy count.
// Assumes DEPTH is a power of two. A push while full and a pop while empty
// are ignored; the head entry is presented combinationally.
module fir_sync_queue #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] level
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Qualify requests against the current occupancy.
    always_comb begin
        empty   = (level == '0);
        full    = (level == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    assign head_data = store[rd_ptr];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Entry storage, written only on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/fir_tap_core.sv
// fir_tap_core: three-tap fixed-weight filter with warm-up tracking.
// Takes one sample when one is offered and the sink has room. It emits a
// result in the same cycle once two older samples are held in the delay line.
module fir_tap_core
    import fir_accel_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 20,
    parameter int TAPS     = 3,
    localparam int HIST    = TAPS - 1,
    localparam int FILL_W  = $clog2(TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_avail,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                sink_room,
    output logic                smp_take,
    output logic                res_push,
    output logic [ACC_W-1:0]    res_data
);

    logic signed [SAMPLE_W-1:0] hist_q [HIST];
    logic [FILL_W-1:0]          fill_q;
    logic signed [ACC_W-1:0]    ext    [TAPS];
    logic signed [ACC_W-1:0]    acc;

    // A sample moves only when one is waiting and the result has a place.
    assign smp_take = smp_avail && sink_room;
    assign res_push = smp_take && (fill_q == FILL_W'(HIST));

    // Sign-extend every window element, index 0 = incoming sample.
    generate
        for (genvar t = 0; t < TAPS; t++) begin : g_ext
            if (t == 0) begin : g_new
                assign ext[t] = {{(ACC_W-SAMPLE_W){smp_data[SAMPLE_W-1]}}, smp_data};
            end else begin : g_old
                assign ext[t] = {{(ACC_W-SAMPLE_W){hist_q[t-1][SAMPLE_W-1]}}, hist_q[t-1]};
            end
        end
    endgenerate

    // Weighted sum of the window.
    always_comb begin
        acc = '0;
        for (int t = 0; t < TAPS; t++) begin
            acc = acc + ext[t] * $signed(ACC_W'(tap_weight(t)));
        end
    end

    assign res_data = acc;

    // Delay-line shift on every taken sample.
    generate
        for (genvar h = 0; h < HIST; h++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q[h] <= '0;
                end else if (smp_take) begin
                    if (h == 0) hist_q[h] <= smp_data;
                    else        hist_q[h] <= hist_q[h-1];
                end
            end
        end
    endgenerate

    // Warm-up counter saturating once the history is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (smp_take && fill_q != FILL_W'(HIST)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

endmodule

// File: rtl/fir_reg_decode.sv
// fir_reg_decode: turns a bus request into a register select.
// Assumes offsets are compared in full; direction must match the register.
module fir_reg_decode
    import fir_accel_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output reg_sel_e          sel
);

    // Map offset and direction to a register.
    always_comb begin
        sel = SEL_NONE;
        if (req_valid) begin
            if (req_write) begin
                if (req_addr == ADDR_W'(OFS_SAMPLE_PUSH)) sel = SEL_PUSH;
            end else begin
                case (req_addr)
                    ADDR_W'(OFS_IN_LEVEL):   sel = SEL_IN_LEVEL;
                    ADDR_W'(OFS_RESULT_POP): sel = SEL_POP;
                    ADDR_W'(OFS_OUT_LEVEL):  sel = SEL_OUT_LEVEL;
                    default:                 sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/mmio_fir_accel.sv
// mmio_fir_accel: register-bus FIR peripheral. Samples are pushed through
// one offset, results popped through another, and both queue levels can be
// read. Assumes one request per cycle and read data sampled one cycle later.
module mmio_fir_accel
    import fir_accel_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 20,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 64,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);

    reg_sel_e            sel;
    logic [SAMPLE_W-1:0] in_head;
    logic                in_empty;
    logic                in_full;
    logic [CNT_W-1:0]    in_count;
    logic [ACC_W-1:0]    out_head;
    logic                out_empty;
    logic                out_full;
    logic [CNT_W-1:0]    out_count;
    logic                core_take;
    logic                out_push;
    logic [ACC_W-1:0]    core_res;
    logic [DATA_W-1:0]   rdata_q;

    fir_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .sel       (sel)
    );

    fir_sync_queue #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_in_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sel == SEL_PUSH),
        .push_data (req_wdata[SAMPLE_W-1:0]),
        .pop       (core_take),
        .head_data (in_head),
        .empty     (in_empty),
        .full      (in_full),
        .level     (in_count)
    );

    fir_tap_core #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .TAPS(3)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_avail (!in_empty),
        .smp_data  (in_head),
        .sink_room (!out_full),
        .smp_take  (core_take),
        .res_push  (out_push),
        .res_data  (core_res)
    );

    fir_sync_queue #(.DEPTH(DEPTH), .WIDTH(ACC_W)) u_out_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (out_push),
        .push_data (core_res),
        .pop       (sel == SEL_POP),
        .head_data (out_head),
        .empty     (out_empty),
        .full      (out_full),
        .level     (out_count)
    );

    // Registered read mux; zero for idle, write and unmapped cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            case (sel)
                SEL_IN_LEVEL:  rdata_q <= DATA_W'(in_count);
                SEL_OUT_LEVEL: rdata_q <= DATA_W'(out_count);
                SEL_POP:       rdata_q <= out_empty ? '0 : DATA_W'(out_head);
                default:       rdata_q <= '0;
            endcase
        end
    end

    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/fir_accel_checker.sv
// fir_accel_checker: temporal properties of the FIR peripheral, bound to
// the top module. Observes ports plus queue levels and the core handshake.
module fir_accel_checker #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [CNT_W-1:0]  in_count,
    input logic [CNT_W-1:0]  out_count,
    input logic              core_take,
    input logic              out_push
);

    logic rd_req;
    logic rd_unmapped;
    assign rd_req      = req_valid && !req_write;
    assign rd_unmapped = rd_req && req_addr != ADDR_W'(12'h008)
                         && req_addr != ADDR_W'(12'h100) && req_addr != ADDR_W'(12'h108);

    AST_IN_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_count <= CNT_W'(DEPTH)); // R4
    AST_OUT_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CNT_W'(DEPTH)); // R4
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count == CNT_W'(DEPTH)) |-> !out_push); // R6
    AST_NO_TAKE_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_count == '0) |-> !core_take); // R6
    AST_OUT_GROWS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |=> out_count <= $past(out_count) + 1'b1); // R6
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> rsp_rdata == '0); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> rsp_rdata == '0); // R8
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == ADDR_W'(12'h100) && out_count == '0) |=> rsp_rdata == '0); // R5

endmodule

bind mmio_fir_accel fir_accel_checker #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_rdata (rsp_rdata),
    .in_count  (in_count),
    .out_count (out_count),
    .core_take (core_take),
    .out_push  (out_push)
);

// File: tb/mmio_fir_accel_test.sv
module mmio_fir_accel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] acc_smp [64];
    int n_acc = 0;
    int n_pop = 0;

    localparam logic [11:0] A_PUSH = 12'h000, A_INL = 12'h008, A_POP = 12'h100, A_OUTL = 12'h108;

    mmio_fir_accel uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] fir_expect(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        int v;
        v = 3 * int'($signed(a)) + 2 * int'($signed(b)) + int'($signed(c));
        return {44'd0, v[19:0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_acc = 0; n_pop = 0;
    endtask

    // Push a sample and record it as accepted.
    task automatic push_smp(input logic [63:0] d);
        bus_write(A_PUSH, d);
        acc_smp[n_acc] = d[15:0];
        n_acc++;
    endtask

    task automatic pop_check(input string req);
        logic [63:0] r;
        bus_read(A_POP, r);
        check(req, r, fir_expect(acc_smp[n_pop], acc_smp[n_pop+1], acc_smp[n_pop+2]));
        n_pop++;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [63:0] r;
        void'($urandom(32'd20240611));
        do_reset();

        // R9 / R1: empty after reset
        bus_read(A_INL, r);  check("R9 in level after reset", r, 64'd0);
        bus_read(A_OUTL, r); check("R9 out level after reset", r, 64'd0);
        // R5: empty pop returns zero and leaves level at zero
        bus_read(A_POP, r);  check("R5 empty pop data", r, 64'd0);
        bus_read(A_OUTL, r); check("R5 level after empty pop", r, 64'd0);

        // R3: warm-up with 1.0, 2.0, 3.0 in 3-bit fraction
        push_smp(64'd8);
        bus_read(A_OUTL, r); check("R3 no result after 1 sample", r, 64'd0);
        push_smp(64'd16);
        bus_read(A_OUTL, r); check("R3 no result after 2 samples", r, 64'd0);
        push_smp(64'd24);
        bus_read(A_OUTL, r); check("R3 one result after 3 samples", r, 64'd1);
        // R7: read one cycle later, zero in following idle cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = A_POP;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 result after one cycle", rsp_rdata, 64'd80);
        check("R2 weighted sum 3a+2b+c", rsp_rdata, fir_expect(16'd8, 16'd16, 16'd24));
        n_pop++;
        @(negedge clk);
        check("R7 idle cycle reads zero", rsp_rdata, 64'd0);

        // R10: upper write bits ignored, negative samples
        push_smp(64'hDEAD_BEEF_CAFE_FFF8);
        pop_check("R10 signed low half with junk upper bits");
        push_smp(64'h0000_0000_0000_8000);
        pop_check("R2 negative full-scale wrap to 20 bits");
        push_smp(64'h1111_0000_0000_7FFF);
        pop_check("R2 mixed sign window");

        // R2 / R3: random stream, one result per sample in order
        for (int i = 0; i < 12; i++) push_smp({48'd0, 16'($urandom)});
        bus_read(A_OUTL, r); check("R3 one result per sample", r, 64'd12);
        for (int i = 0; i < 12; i++) pop_check("R2 random window");

        // R8: unmapped accesses
        bus_write(12'h010, 64'h55);
        bus_write(A_POP, 64'h66);
        bus_write(A_INL, 64'h3);
        bus_read(A_INL, r);  check("R8 in level unchanged", r, 64'd0);
        bus_read(A_OUTL, r); check("R8 out level unchanged", r, 64'd0);
        bus_read(12'h010, r); check("R8 unmapped read zero", r, 64'd0);
        bus_read(A_PUSH, r); check("R8 push offset reads zero", r, 64'd0);

        // R9: reset with data in flight clears state
        push_smp(64'd40);
        push_smp(64'd40);
        do_reset();
        bus_read(A_OUTL, r); check("R9 out level cleared", r, 64'd0);
        push_smp(64'd1);
        bus_read(A_OUTL, r); check("R9 warm-up restarts", r, 64'd0);
        do_reset();

        // R4 / R6: fill both queues
        for (int i = 0; i < 18; i++) push_smp({48'd0, 16'($urandom)});
        bus_read(A_OUTL, r); check("R6 output full", r, 64'd16);
        for (int i = 0; i < 16; i++) push_smp({48'd0, 16'($urandom)});
        bus_read(A_INL, r);  check("R6 stalled input held", r, 64'd16);
        for (int i = 0; i < 4; i++) bus_write(A_PUSH, {48'd0, 16'($urandom)});
        bus_read(A_INL, r);  check("R4 writes when full dropped", r, 64'd16);
        pop_check("R6 first result after stall");
        bus_read(A_INL, r);  check("R6 one sample moved after pop", r, 64'd15);
        bus_read(A_OUTL, r); check("R6 output refilled", r, 64'd16);
        for (int i = 0; i < 31; i++) pop_check("R4 R6 drain order without loss");
        bus_read(A_OUTL, r); check("R6 drained", r, 64'd0);
        bus_read(A_INL, r);  check("R6 input drained", r, 64'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule